// File: doc/BRIEF.md
# Code-Error Driven Sampling Phase Finder

This block chooses the sampling phase of one serial receive lane. Upstream logic reports each line-code violation as a single-cycle pulse. The block counts these pulses over an observation window of fixed length. When the count reaches the selected threshold, the block moves the phase selector to the next of eight positions. Each position shifts the sampling point by roughly 312 ps on the external delay line. The phase only moves while the idle pattern is being received, unless the configuration permits moves during live data.

An 8-bit configuration word sets up the block:

- one bit permits phase moves during data traffic;
- three bits select the error threshold;
- two bits select the window length;
- the two top bits are spare and have no effect.

The window length is derived from a clock-frequency parameter, so the same code gives the same wall-clock window at any clock rate. A manual load port lets firmware force a phase directly. A load also restarts the observation window.

Top module: `lane_phase_hunter`

## Requirements
- R1: After reset, `phase_o` is 0x8 and `step_o` is low.
- R2: Threshold selection. `cfg_i[1]` selects 1 error, `cfg_i[2]` selects 16 and `cfg_i[3]` selects 512. When several of these bits are set, the smallest selected threshold applies. When none is set, the threshold is 1.
- R3: The error count is registered one clock edge after the error pulse is sampled. If that registered count has reached the threshold and the step is allowed, the next clock edge does three things at once: it advances `phase_o` by one, it raises `step_o` for exactly one cycle, and it clears the count.
- R4: An automatic step from phase 0xF goes to 0x8. `phase_o` always stays within 0x8 to 0xF.
- R5: With `cfg_i[0]` clear, a step is taken only while `idle_i` is high. A count that has reached the threshold is held, and the step fires on the first edge at which `idle_i` is high. With `cfg_i[0]` set, `idle_i` does not matter.
- R6: Window length. With W = CLK_HZ/16 cycles (about 62.5 ms), `cfg_i[5:4]` = 00 gives W, 01 gives 2W, and both 10 and 11 give 4W. On the last cycle of a window the error count clears, and an error pulse sampled on that closing edge is discarded.
- R7: An automatic step clears the error count and restarts the window, so the new phase gets a fresh, full-length window.
- R8: While `load_i` is high, the next edge loads `load_phase_i` into `phase_o`. A value below 0x8 is clamped to 0x8. The load clears the count, restarts the window and does not raise `step_o`. A load takes priority over a step on the same edge.
- R9: The error count saturates at 2^CNT_W-1 (1023 with the default 512 threshold) rather than wrapping to zero.
- R10: `cfg_i[7:6]` have no effect on behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_err_i | input | 1 | One-cycle pulse for each line-code error |
| idle_i | input | 1 | High while the idle pattern is received |
| cfg_i | input | 8 | Bit 0: allow moves during data; bits 3..1: threshold; bits 5..4: window; bits 7..6: spare |
| load_i | input | 1 | Manual phase load strobe |
| load_phase_i | input | 4 | Phase value to load |
| phase_o | output | 4 | Phase selector, 0x8..0xF |
| step_o | output | 1 | One-cycle pulse on each automatic phase step |

## Verification
The properties take `code_err_i` to be a pulse train sampled once per edge, with no other meaning. They take `load_i` to be a plain strobe whose phase value is valid in the same cycle. They expect `cfg_i` to change only when a load restarts the window. The stimulus follows these assumptions: it changes the configuration only before issuing a load, drives every input on the falling edge, and counts each error and idle cycle relative to the load edge. This lets the window boundaries and the step edge be predicted to the exact cycle.

// File: rtl/phase_hunt_pkg.sv
package phase_hunt_pkg;

   localparam logic [3:0] PH_MIN = 4'h8;
   localparam logic [3:0] PH_MAX = 4'hF;

   typedef enum logic [1:0] {
      WIN_BASE  = 2'b00,
      WIN_DBL   = 2'b01,
      WIN_QUAD  = 2'b10,
      WIN_QUAD2 = 2'b11
   } win_sel_e;

   typedef struct packed {
      logic       spare_hi;
      logic       spare_lo;
      win_sel_e   win;
      logic [2:0] th_sel;
      logic       allow_data;
   } cfg_t;

   function automatic logic [3:0] clamp_phase(input logic [3:0] v);
      return v[3] ? v : PH_MIN;
   endfunction

   function automatic logic [3:0] next_phase(input logic [3:0] v);
      return (v == PH_MAX) ? PH_MIN : v + 4'd1;
   endfunction

endpackage

// File: rtl/phase_cfg_decode.sv
module phase_cfg_decode
   import phase_hunt_pkg::*;
#(
   parameter int CNT_W         = 10,
   parameter int TH_LO         = 1,
   parameter int TH_MID        = 16,
   parameter int TH_HI         = 512,
   parameter bit PICK_SMALLEST = 1'b1
) (
   input  logic [7:0]       cfg_i,
   output logic             allow_data_o,
   output logic [CNT_W-1:0] thr_o,
   output win_sel_e         win_o
);

   cfg_t cfg;
   logic unused_spare;

   assign cfg          = cfg_t'(cfg_i);
   assign allow_data_o = cfg.allow_data;
   assign win_o        = cfg.win;
   assign unused_spare = cfg.spare_hi ^ cfg.spare_lo;

   localparam logic [CNT_W-1:0] T_LO  = CNT_W'(TH_LO);
   localparam logic [CNT_W-1:0] T_MID = CNT_W'(TH_MID);
   localparam logic [CNT_W-1:0] T_HI  = CNT_W'(TH_HI);

   generate
      if (PICK_SMALLEST) begin : g_small_first
         always_comb begin
            if (cfg.th_sel[0])      thr_o = T_LO;
            else if (cfg.th_sel[1]) thr_o = T_MID;
            else if (cfg.th_sel[2]) thr_o = T_HI;
            else                    thr_o = T_LO;
         end
      end else begin : g_large_first
         always_comb begin
            if (cfg.th_sel[2])      thr_o = T_HI;
            else if (cfg.th_sel[1]) thr_o = T_MID;
            else                    thr_o = T_LO;
         end
      end
   endgenerate

endmodule

// File: rtl/phase_window_timer.sv
module phase_window_timer
   import phase_hunt_pkg::*;
#(
   parameter int BASE_TICKS = 7_812_500,
   parameter int TMR_W      = 25
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     restart_i,
   input  win_sel_e win_i,
   output logic     end_o
);

   logic [TMR_W-1:0] len_tab [4];
   logic [TMR_W-1:0] len;
   logic [TMR_W-1:0] cnt_q;

   for (genvar g = 0; g < 4; g++) begin : g_len
      localparam int SHIFT = (g == 3) ? 2 : g;
      assign len_tab[g] = TMR_W'(BASE_TICKS) << SHIFT;
   end

   always_comb begin
      case (win_i)
         WIN_BASE: len = len_tab[0];
         WIN_DBL:  len = len_tab[1];
         WIN_QUAD: len = len_tab[2];
         default:  len = len_tab[3];
      endcase
   end

   assign end_o = (cnt_q >= len - TMR_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 cnt_q <= '0;
      else if (restart_i || end_o) cnt_q <= '0;
      else                         cnt_q <= cnt_q + TMR_W'(1);
   end

endmodule

// File: rtl/phase_err_counter.sv
module phase_err_counter #(
   parameter int CNT_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             inc_i,
   input  logic [CNT_W-1:0] thr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             armed_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       cnt_o <= '0;
      else if (clr_i)                    cnt_o <= '0;
      else if (inc_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + CNT_W'(1);
   end

   assign armed_o = (cnt_o >= thr_i);

endmodule

// File: rtl/phase_step_reg.sv
module phase_step_reg
   import phase_hunt_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       load_i,
   input  logic [3:0] load_val_i,
   input  logic       step_i,
   output logic [3:0] phase_o,
   output logic       strobe_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_o  <= PH_MIN;
         strobe_o <= 1'b0;
      end else if (load_i) begin
         phase_o  <= clamp_phase(load_val_i);
         strobe_o <= 1'b0;
      end else if (step_i) begin
         phase_o  <= next_phase(phase_o);
         strobe_o <= 1'b1;
      end else begin
         strobe_o <= 1'b0;
      end
   end

endmodule

// File: rtl/lane_phase_hunter.sv
module lane_phase_hunter
   import phase_hunt_pkg::*;
#(
   parameter int CLK_HZ        = 125_000_000,
   parameter int TH_LO         = 1,
   parameter int TH_MID        = 16,
   parameter int TH_HI         = 512,
   parameter bit PICK_SMALLEST = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       code_err_i,
   input  logic       idle_i,
   input  logic [7:0] cfg_i,
   input  logic       load_i,
   input  logic [3:0] load_phase_i,
   output logic [3:0] phase_o,
   output logic       step_o
);

   localparam int BASE_TICKS = CLK_HZ / 16;
   localparam int TMR_W      = $clog2(4 * BASE_TICKS + 1);
   localparam int CNT_W      = $clog2(TH_HI + 1);

   generate
      if (BASE_TICKS < 2)
         $error("window base too short for CLK_HZ");
      if (!(TH_LO >= 1 && TH_LO <= TH_MID && TH_MID <= TH_HI))
         $error("thresholds must be ordered and non-zero");
   endgenerate

   logic             allow_data;
   logic [CNT_W-1:0] thr;
   win_sel_e         win;
   logic             win_end;
   logic [CNT_W-1:0] err_cnt;
   logic             armed;
   logic             step_req;
   logic             restart;
   logic             cnt_clr;

   assign step_req = armed && (idle_i || allow_data) && !load_i;
   assign restart  = load_i || step_req;
   assign cnt_clr  = restart || win_end;

   phase_cfg_decode #(
      .CNT_W(CNT_W), .TH_LO(TH_LO), .TH_MID(TH_MID), .TH_HI(TH_HI),
      .PICK_SMALLEST(PICK_SMALLEST)
   ) u_cfg (
      .cfg_i       (cfg_i),
      .allow_data_o(allow_data),
      .thr_o       (thr),
      .win_o       (win)
   );

   phase_window_timer #(.BASE_TICKS(BASE_TICKS), .TMR_W(TMR_W)) u_win (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .restart_i(restart),
      .win_i    (win),
      .end_o    (win_end)
   );

   phase_err_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (cnt_clr),
      .inc_i  (code_err_i),
      .thr_i  (thr),
      .cnt_o  (err_cnt),
      .armed_o(armed)
   );

   phase_step_reg u_phase (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load_i),
      .load_val_i(load_phase_i),
      .step_i    (step_req),
      .phase_o   (phase_o),
      .strobe_o  (step_o)
   );

endmodule

// File: rtl/lane_phase_hunter_chk.sv
module lane_phase_hunter_chk #(
   parameter int CNT_W = 10
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             idle_i,
   input logic [7:0]       cfg_i,
   input logic             load_i,
   input logic [3:0]       load_phase_i,
   input logic [3:0]       phase_o,
   input logic             step_o,
   input logic [CNT_W-1:0] err_cnt,
   input logic             cnt_clr
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   a_r1_reset_state: assert property (@(posedge clk_i)
      !rst_ni |=> (phase_o == 4'h8 && !step_o));

   a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_o |=> !step_o);

   a_r3_step_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_o && $past(rst_ni)) |->
         phase_o == (($past(phase_o) == 4'hF) ? 4'h8 : $past(phase_o) + 4'd1));

   a_r4_phase_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      phase_o[3]);

   a_r5_gated_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_o && $past(rst_ni) && !$past(cfg_i[0])) |-> $past(idle_i));

   a_r8_load_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(load_i) && $past(rst_ni)) |->
         (!step_o && phase_o == ($past(load_phase_i[3]) ? $past(load_phase_i) : 4'h8)));

   a_r9_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_cnt == CNT_MAX) |=> (err_cnt == CNT_MAX || err_cnt == '0));

   a_r9_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !$past(cnt_clr)) |-> (err_cnt >= $past(err_cnt)));

endmodule

bind lane_phase_hunter lane_phase_hunter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .idle_i      (idle_i),
   .cfg_i       (cfg_i),
   .load_i      (load_i),
   .load_phase_i(load_phase_i),
   .phase_o     (phase_o),
   .step_o      (step_o),
   .err_cnt     (err_cnt),
   .cnt_clr     (cnt_clr)
);

// File: tb/lane_phase_hunter_tb.sv
module lane_phase_hunter_tb;

   localparam int CLK_HZ = 32_000;
   localparam int W      = CLK_HZ / 16;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       code_err_i = 1'b0;
   logic       idle_i = 1'b1;
   logic [7:0] cfg_i = 8'h02;
   logic       load_i = 1'b0;
   logic [3:0] load_phase_i = 4'h0;
   logic [3:0] phase_o;
   logic       step_o;

   int n_checks = 0;
   int n_fails  = 0;
   logic [3:0] exp_q [$];
   string      tag_q [$];
   bit         done = 1'b0;

   always #4 clk_i = ~clk_i;

   lane_phase_hunter #(.CLK_HZ(CLK_HZ)) u_dut (
      .clk_i(clk_i), .rst_ni(rst_ni), .code_err_i(code_err_i), .idle_i(idle_i),
      .cfg_i(cfg_i), .load_i(load_i), .load_phase_i(load_phase_i),
      .phase_o(phase_o), .step_o(step_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic expect_step(input logic [3:0] ph, input string tag);
      exp_q.push_back(ph);
      tag_q.push_back(tag);
   endtask

   // monitor: every strobe must match a queued expected phase
   always @(negedge clk_i) begin
      if (rst_ni && step_o) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "unexpected step (R2/R5/R6/R7)", int'(phase_o), 0);
         end else begin
            logic [3:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(phase_o == e, t, int'(phase_o), int'(e));
         end
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk_i);
   endtask

   task automatic pulse_err();
      code_err_i = 1'b1;
      @(negedge clk_i);
      code_err_i = 1'b0;
   endtask

   task automatic do_load(input logic [3:0] v);
      load_i = 1'b1;
      load_phase_i = v;
      @(negedge clk_i);
      load_i = 1'b0;
   endtask

   // 15 errors after a load, then one more error on edge L+W-1 (early) or L+W (late)
   task automatic window_probe(input logic [7:0] cfg, input int len, input bit late, input string tag);
      cfg_i = cfg;
      idle_i = 1'b1;
      do_load(4'h8);
      repeat (15) pulse_err();
      cycles(len - 17 + (late ? 1 : 0));
      if (!late) expect_step(4'h9, tag);
      pulse_err();
      @(negedge clk_i);
      check(step_o == !late, tag, int'(step_o), int'(!late));
      check(phase_o == (late ? 4'h8 : 4'h9), tag, int'(phase_o), late ? 8 : 9);
   endtask

   initial begin : watchdog
      repeat (200_000) @(posedge clk_i);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin : stim
      cycles(3);
      rst_ni = 1'b1;
      @(negedge clk_i);
      check(phase_o == 4'h8, "R1 reset phase", int'(phase_o), 8);
      check(step_o == 1'b0, "R1 reset strobe", int'(step_o), 0);

      // R3 basic timing, threshold 1
      cfg_i = 8'h02;
      do_load(4'h8);
      expect_step(4'h9, "R3 step phase");
      pulse_err();
      check(step_o == 1'b0, "R3 no step yet", int'(step_o), 0);
      @(negedge clk_i);
      check(step_o == 1'b1, "R3 strobe on step edge", int'(step_o), 1);
      @(negedge clk_i);
      check(step_o == 1'b0, "R3 strobe one cycle", int'(step_o), 0);
      check(phase_o == 4'h9, "R3 phase held", int'(phase_o), 9);

      // R4 wrap
      do_load(4'hF);
      check(phase_o == 4'hF, "R8 load F", int'(phase_o), 15);
      expect_step(4'h8, "R4 wrap");
      pulse_err();
      @(negedge clk_i);
      check(phase_o == 4'h8, "R4 wrap to 8", int'(phase_o), 8);

      // R8 load clamp, no strobe
      do_load(4'h3);
      check(phase_o == 4'h8, "R8 clamp", int'(phase_o), 8);
      check(step_o == 1'b0, "R8 no strobe on load", int'(step_o), 0);
      do_load(4'hC);
      check(phase_o == 4'hC, "R8 load C", int'(phase_o), 12);

      // R2 several threshold bits: 16 wins over 512
      cfg_i = 8'h0C;
      do_load(4'h8);
      repeat (15) pulse_err();
      @(negedge clk_i);
      check(phase_o == 4'h8, "R2 15 errors below 16", int'(phase_o), 8);
      expect_step(4'h9, "R2 sixteenth error");
      pulse_err();
      @(negedge clk_i);
      check(phase_o == 4'h9, "R2 step at 16", int'(phase_o), 9);

      // R2 no threshold bit -> 1; R10 spare bits ignored
      cfg_i = 8'h00;
      do_load(4'h8);
      expect_step(4'h9, "R2 none set means 1");
      pulse_err();
      @(negedge clk_i);
      check(phase_o == 4'h9, "R2 none set", int'(phase_o), 9);
      cfg_i = 8'hC2;
      do_load(4'hA);
      expect_step(4'hB, "R10 spare bits");
      pulse_err();
      @(negedge clk_i);
      check(phase_o == 4'hB, "R10 spare bits ignored", int'(phase_o), 11);

      // R5 gating
      cfg_i = 8'h02;
      idle_i = 1'b0;
      do_load(4'h8);
      pulse_err();
      cycles(5);
      check(phase_o == 4'h8, "R5 held during data", int'(phase_o), 8);
      expect_step(4'h9, "R5 step on idle");
      idle_i = 1'b1;
      @(negedge clk_i);
      check(step_o == 1'b1, "R5 step once idle", int'(step_o), 1);
      cfg_i = 8'h03;
      idle_i = 1'b0;
      do_load(4'h8);
      expect_step(4'h9, "R5 allowed during data");
      pulse_err();
      @(negedge clk_i);
      check(phase_o == 4'h9, "R5 data allowed", int'(phase_o), 9);
      idle_i = 1'b1;

      // R6 window lengths
      window_probe(8'h04, W,     1'b0, "R6 win00 last cycle");
      window_probe(8'h04, W,     1'b1, "R6 win00 closing edge");
      window_probe(8'h14, 2 * W, 1'b0, "R6 win01 last cycle");
      window_probe(8'h14, 2 * W, 1'b1, "R6 win01 closing edge");
      window_probe(8'h24, 4 * W, 1'b0, "R6 win10 last cycle");
      window_probe(8'h34, 4 * W, 1'b1, "R6 win11 closing edge");

      // R7 fresh count and window after a step
      cfg_i = 8'h04;
      do_load(4'h8);
      expect_step(4'h9, "R7 first step");
      repeat (16) pulse_err();
      @(negedge clk_i);
      repeat (15) pulse_err();
      check(phase_o == 4'h9, "R7 count cleared by step", int'(phase_o), 9);
      cycles(W - 17);
      expect_step(4'hA, "R7 window restarted");
      pulse_err();
      @(negedge clk_i);
      check(phase_o == 4'hA, "R7 window restarted at step", int'(phase_o), 10);

      // R9 saturation: 1100 errors while gated, then idle
      cfg_i = 8'h38;
      idle_i = 1'b0;
      do_load(4'h8);
      repeat (1100) pulse_err();
      expect_step(4'h9, "R9 saturated count");
      idle_i = 1'b1;
      @(negedge clk_i);
      check(step_o == 1'b1, "R9 count saturated not wrapped", int'(step_o), 1);

      cycles(3);
      check(exp_q.size() == 0, "R3 all expected steps seen", exp_q.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule